// File: doc/BRIEF.md
# Reset Source Capture Controller

This block merges seven reset requests into a single active-high system reset and remembers which request started the most recent reset. The requests are: the asynchronous power-on input, a supply-monitor request, the external reset pin, a watchdog timeout, a missing-clock timeout, an active-low comparator request and a flash access error. Apart from `por_n`, all request inputs are taken to be already synchronous to `clk`.

Software sees one 8-bit register with separate read and write strobes, and a read and a write to the same bit mean different things. A read returns the latched cause flags, with one bit per source. A write sets the enables for the supply monitor, the missing-clock detector and the comparator. Writing 1 to the software bit forces a reset. The supply-monitor and missing-clock enables are also driven out to the external circuits that produce those requests.

The system reset output is stretched by a fixed number of cycles after the last request goes away. The cause flags are sampled only on the first cycle of a reset.

Top module: `rst_cause_ctrl`

## Requirements
- R1: A cycle with `reg_rd` high loads `reg_rdata` at that clock edge with the cause flags, bit 7 being 0. The flag positions are: pin 0, supply/power-on 1, missing clock 2, watchdog 3, software 4, comparator 5, flash error 6.
- R2: Bit 7 of `reg_rdata` is always 0. A write of 0x80 sets no flag and forces no reset.
- R3: While `por_n` is low, `sys_rst` is high. The flags read 0x02, `sup_mon_en` is 1, `mcd_en` is 0 and the comparator is disabled. After `por_n` rises, `sys_rst` stays high for 16 more cycles.
- R4: An enabled request sampled at a clock edge drives `sys_rst` high from that edge. `sys_rst` stays high for exactly 16 cycles after the last edge at which any request was sampled.
- R5: Pin, watchdog and flash requests are always enabled, and each leaves the flags reading 0x01, 0x08 or 0x40 respectively.
- R6: A write with data bit 4 set, made while `sys_rst` is low, forces a reset and the flags then read 0x10. A write with bit 4 clear forces no reset.
- R7: Write bit 5 enables the comparator. A low `cmp_req_n` then causes a reset with flags 0x20. While the comparator is disabled, a low `cmp_req_n` is ignored.
- R8: Write bit 2 drives `mcd_en`. When `mcd_en` is 1, `mcd_req` causes a reset with flags 0x04. When `mcd_en` is 0, `mcd_req` is ignored.
- R9: Write bit 1 drives `sup_mon_en`. When `sup_mon_en` is 1, `sup_req` causes a reset with flags 0x02. When `sup_mon_en` is 0, `sup_req` is ignored.
- R10: If several enabled requests are sampled at the same edge, exactly one flag is set. The supply request wins over all others; otherwise the lowest bit number wins.
- R11: Requests that arrive while `sys_rst` is already high restart the 16-cycle hold but leave the flags unchanged.
- R12: A reset from any source other than `por_n` keeps all enable settings.
- R13: Writes made while `sys_rst` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_req | input | 1 | External pin reset request |
| sup_req | input | 1 | Supply monitor reset request |
| mcd_req | input | 1 | Missing-clock timeout request |
| wdt_req | input | 1 | Watchdog timeout request |
| cmp_req_n | input | 1 | Comparator reset request, active low |
| flash_req | input | 1 | Flash access error request |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Captured register read data |
| sup_mon_en | output | 1 | Supply monitor enable |
| mcd_en | output | 1 | Missing-clock detector enable |
| sys_rst | output | 1 | Stretched system reset, active high |

## Verification
The bench drives requests from disabled sources and checks that `sys_rst` stays low. A design that did not gate disabled sources would reset on comparator, clock-loss or supply noise. Requests are also raised together, which catches a design that sets several flags or ranks the supply request below the pin. A second request is raised in the middle of a reset, which catches a design that overwrites the first cause or fails to restart the hold. Writes are issued during reset, and a power-on is applied after the enables have been changed, to show which resets keep the enables and which restore them.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
   localparam int NSRC  = 7;
   localparam int REG_W = 8;
   localparam int B_PIN   = 0;
   localparam int B_SUP   = 1;
   localparam int B_MCD   = 2;
   localparam int B_WDT   = 3;
   localparam int B_SW    = 4;
   localparam int B_CMP   = 5;
   localparam int B_FLASH = 6;
   localparam logic [NSRC-1:0] POR_CAUSE = NSRC'(1) << B_SUP;
endpackage

// File: rtl/rcc_req_gate.sv
module rcc_req_gate
   import rcc_pkg::*;
(
   input  logic            pin_req,
   input  logic            sup_req,
   input  logic            mcd_req,
   input  logic            wdt_req,
   input  logic            cmp_req_n,
   input  logic            flash_req,
   input  logic            sw_req,
   input  logic            en_sup,
   input  logic            en_mcd,
   input  logic            en_cmp,
   output logic [NSRC-1:0] req_vec
);
   always_comb begin
      req_vec          = '0;
      req_vec[B_PIN]   = pin_req;
      req_vec[B_SUP]   = sup_req & en_sup;
      req_vec[B_MCD]   = mcd_req & en_mcd;
      req_vec[B_WDT]   = wdt_req;
      req_vec[B_SW]    = sw_req;
      req_vec[B_CMP]   = ~cmp_req_n & en_cmp;
      req_vec[B_FLASH] = flash_req;
   end
endmodule

// File: rtl/rcc_prio.sv
module rcc_prio #(
   parameter int N     = 7,
   parameter int BOOST = 1
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] win
);
   function automatic logic [N-1:0] beats(input int i);
      logic [N-1:0] m;
      m = '0;
      for (int j = 0; j < N; j++)
         if (i != BOOST && (j == BOOST || j < i)) m[j] = 1'b1;
      return m;
   endfunction

   generate
      if (BOOST < 0 || BOOST >= N) begin : g_bad_boost
         $error("rcc_prio: BOOST out of range");
      end
      for (genvar i = 0; i < N; i++) begin : g_rank
         localparam logic [N-1:0] OVER = beats(i);
         assign win[i] = req[i] & ~(|(req & OVER));
      end
   endgenerate
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_any,
   output logic active,
   output logic first
);
   localparam int CNT_W = $clog2(HOLD + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= LOAD;
      else if (req_any)        cnt_q <= LOAD;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign active = (cnt_q != '0);
   assign first  = req_any & ~active;
endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
   import rcc_pkg::*;
#(
   parameter int HOLD_CYCLES = 16,
   parameter bit RDATA_REG   = 1'b1
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             pin_req,
   input  logic             sup_req,
   input  logic             mcd_req,
   input  logic             wdt_req,
   input  logic             cmp_req_n,
   input  logic             flash_req,
   input  logic             reg_wr,
   input  logic             reg_rd,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             sup_mon_en,
   output logic             mcd_en,
   output logic             sys_rst
);
   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("rst_cause_ctrl: HOLD_CYCLES must be at least 1");
      end
      if (REG_W != NSRC + 1) begin : g_bad_width
         $error("rst_cause_ctrl: register width must be sources plus one");
      end
   endgenerate

   logic            wr_ok, sw_req, req_any, first;
   logic            en_cmp_q;
   logic [NSRC-1:0] req_vec, win, cause_q;
   logic [REG_W-1:0] read_val;
   logic            unused_wdata;

   assign wr_ok        = reg_wr & ~sys_rst;
   assign sw_req       = wr_ok & reg_wdata[B_SW];
   assign unused_wdata = ^{reg_wdata[REG_W-1], reg_wdata[B_PIN], reg_wdata[B_WDT], reg_wdata[B_FLASH]};

   rcc_req_gate u_gate (
      .pin_req   (pin_req),
      .sup_req   (sup_req),
      .mcd_req   (mcd_req),
      .wdt_req   (wdt_req),
      .cmp_req_n (cmp_req_n),
      .flash_req (flash_req),
      .sw_req    (sw_req),
      .en_sup    (sup_mon_en),
      .en_mcd    (mcd_en),
      .en_cmp    (en_cmp_q),
      .req_vec   (req_vec)
   );

   rcc_prio #(.N(NSRC), .BOOST(B_SUP)) u_prio (
      .req (req_vec),
      .win (win)
   );

   assign req_any = |req_vec;

   rcc_stretch #(.HOLD(HOLD_CYCLES)) u_stretch (
      .clk     (clk),
      .rst_n   (por_n),
      .req_any (req_any),
      .active  (sys_rst),
      .first   (first)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     cause_q <= POR_CAUSE;
      else if (first) cause_q <= win;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sup_mon_en <= 1'b1;
         mcd_en     <= 1'b0;
         en_cmp_q   <= 1'b0;
      end else if (wr_ok) begin
         sup_mon_en <= reg_wdata[B_SUP];
         mcd_en     <= reg_wdata[B_MCD];
         en_cmp_q   <= reg_wdata[B_CMP];
      end
   end

   assign read_val = {1'b0, cause_q};

   generate
      if (RDATA_REG) begin : g_rd_flop
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)      reg_rdata <= '0;
            else if (reg_rd) reg_rdata <= read_val;
         end
      end else begin : g_rd_comb
         assign reg_rdata = reg_rd ? read_val : '0;
      end
   endgenerate
endmodule

module rcc_chk
   import rcc_pkg::*;
(
   input logic             clk,
   input logic             por_n,
   input logic             sys_rst,
   input logic             req_any,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] rdata,
   input logic [NSRC-1:0]  cause
);
   AST_BIT7_LOW: assert property (@(posedge clk) disable iff (!por_n)
      rdata[REG_W-1] == 1'b0); // R2

   AST_REQ_TO_RST: assert property (@(posedge clk) disable iff (!por_n)
      req_any |=> sys_rst); // R4

   AST_STRETCH_END: assert property (@(posedge clk) disable iff (!por_n)
      $fell(sys_rst) |-> !$past(req_any)); // R4

   AST_SW_FORCE: assert property (@(posedge clk) disable iff (!por_n)
      (reg_wr && !sys_rst && reg_wdata[B_SW]) |=> sys_rst); // R6

   AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
      $rose(sys_rst) |-> $onehot(cause)); // R10

   AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!por_n)
      $past(sys_rst) |-> $stable(cause)); // R11
endmodule

bind rst_cause_ctrl rcc_chk u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .sys_rst   (sys_rst),
   .req_any   (req_any),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .rdata     (reg_rdata),
   .cause     (cause_q)
);

// File: tb/rst_cause_ctrl_tb.sv
`timescale 1ns/1ps
module rst_cause_ctrl_tb;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       pin_req = 0, sup_req = 0, mcd_req = 0, wdt_req = 0, flash_req = 0;
   logic       cmp_req_n = 1'b1;
   logic       reg_wr = 0, reg_rd = 0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       sup_mon_en, mcd_en, sys_rst;

   always #2.5 clk = ~clk;

   rst_cause_ctrl u_dut (
      .clk(clk), .por_n(por_n), .pin_req(pin_req), .sup_req(sup_req),
      .mcd_req(mcd_req), .wdt_req(wdt_req), .cmp_req_n(cmp_req_n),
      .flash_req(flash_req), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sup_mon_en(sup_mon_en), .mcd_en(mcd_en), .sys_rst(sys_rst)
   );

   int errors = 0, checks = 0, cycles = 0;
   localparam int HOLD = 16;
   localparam int LIMIT = 20000;

   int       m_cnt = HOLD;
   bit [6:0] m_flags = 7'h02;
   bit       m_sup = 1, m_mcd = 0, m_cmp = 0;
   bit [7:0] m_rdata = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   task automatic model_step();
      bit [6:0] r, pick;
      bit busy, wr_ok;
      if (!por_n) begin
         m_cnt = HOLD; m_flags = 7'h02; m_sup = 1; m_mcd = 0; m_cmp = 0; m_rdata = 0;
         return;
      end
      busy  = (m_cnt != 0);
      wr_ok = reg_wr && !busy;
      if (reg_rd) m_rdata = {1'b0, m_flags};
      r = '0;
      r[0] = pin_req;
      r[1] = sup_req && m_sup;
      r[2] = mcd_req && m_mcd;
      r[3] = wdt_req;
      r[4] = wr_ok && reg_wdata[4];
      r[5] = !cmp_req_n && m_cmp;
      r[6] = flash_req;
      pick = '0;
      if (r[1]) pick[1] = 1;
      else for (int k = 0; k < 7; k++) if (r[k] && pick == 0) pick[k] = 1;
      if (r != 0) begin
         if (!busy) m_flags = pick;
         m_cnt = HOLD;
      end else if (m_cnt > 0) m_cnt--;
      if (wr_ok) begin
         m_sup = reg_wdata[1]; m_mcd = reg_wdata[2]; m_cmp = reg_wdata[5];
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      cycles++;
      chk("R4 sys_rst vs model", sys_rst, (m_cnt != 0));
      chk("R1 rdata vs model", reg_rdata, m_rdata);
      chk("R9 sup_mon_en vs model", sup_mon_en, m_sup);
      chk("R8 mcd_en vs model", mcd_en, m_mcd);
      if (cycles > LIMIT) begin
         checks++; errors++;
         $display("FAIL R4 watchdog: actual=%0d cycles expected<%0d", cycles, LIMIT);
         finish_run();
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic wr(input logic [7:0] v);
      reg_wr = 1; reg_wdata = v; cyc(); reg_wr = 0; reg_wdata = '0;
   endtask

   task automatic rd(output logic [7:0] v);
      reg_rd = 1; cyc(); reg_rd = 0; v = reg_rdata;
   endtask

   task automatic drain(output int n);
      n = 0;
      while (sys_rst) begin n++; cyc(); end
   endtask

   initial begin
      logic [7:0] v;
      int n;
      @(negedge clk);
      idle(3);
      chk("R3 reset held during por", sys_rst, 1);
      chk("R3 sup_mon_en after por", sup_mon_en, 1);
      chk("R3 mcd_en after por", mcd_en, 0);
      por_n = 1;
      drain(n);
      chk("R3 hold after por release", n, HOLD);
      rd(v); chk("R3 flags after por", v, 8'h02);

      wr(8'h80);
      chk("R2 write bit7 no reset", sys_rst, 0);
      rd(v); chk("R2 bit7 reads zero", v, 8'h02);

      pin_req = 1; cyc(); pin_req = 0;
      drain(n); chk("R4 stretch length", n, HOLD);
      rd(v); chk("R5 pin flag", v, 8'h01);
      wdt_req = 1; cyc(); wdt_req = 0; drain(n);
      rd(v); chk("R5 watchdog flag", v, 8'h08);
      flash_req = 1; cyc(); flash_req = 0; drain(n);
      rd(v); chk("R5 flash flag", v, 8'h40);

      wr(8'h00); chk("R6 bit4 clear no reset", sys_rst, 0);
      wr(8'h10); chk("R6 forced reset", sys_rst, 1);
      drain(n); rd(v); chk("R6 software flag", v, 8'h10);

      cmp_req_n = 0; idle(3); chk("R7 disabled comparator ignored", sys_rst, 0);
      cmp_req_n = 1;
      wr(8'h20); cmp_req_n = 0; cyc(); cmp_req_n = 1; drain(n);
      rd(v); chk("R7 comparator flag", v, 8'h20);
      cmp_req_n = 0; cyc(); cmp_req_n = 1;
      chk("R12 comparator still enabled", sys_rst, 1);
      drain(n);

      mcd_req = 1; idle(3); chk("R8 disabled clock detector ignored", sys_rst, 0);
      mcd_req = 0;
      wr(8'h04); chk("R8 mcd_en set", mcd_en, 1);
      mcd_req = 1; cyc(); mcd_req = 0; drain(n);
      rd(v); chk("R8 missing clock flag", v, 8'h04);

      wr(8'h00); chk("R9 sup_mon_en cleared", sup_mon_en, 0);
      sup_req = 1; idle(3); chk("R9 disabled supply ignored", sys_rst, 0);
      sup_req = 0;
      wr(8'h02); sup_req = 1; cyc(); sup_req = 0; drain(n);
      rd(v); chk("R9 supply flag", v, 8'h02);

      wr(8'h26);
      pin_req = 1; wdt_req = 1; flash_req = 1; mcd_req = 1; cyc();
      pin_req = 0; wdt_req = 0; flash_req = 0; mcd_req = 0; drain(n);
      rd(v); chk("R10 lowest bit wins", v, 8'h01);
      sup_req = 1; pin_req = 1; cyc(); sup_req = 0; pin_req = 0; drain(n);
      rd(v); chk("R10 supply beats pin", v, 8'h02);
      wdt_req = 1; flash_req = 1; cmp_req_n = 0; cyc();
      wdt_req = 0; flash_req = 0; cmp_req_n = 1; drain(n);
      rd(v); chk("R10 watchdog beats comparator and flash", v, 8'h08);

      pin_req = 1; cyc(); pin_req = 0; idle(4);
      wr(8'h00);
      chk("R13 write during reset ignored", mcd_en, 1);
      wdt_req = 1; cyc(); wdt_req = 0;
      drain(n); chk("R11 hold restarted", n, HOLD);
      rd(v); chk("R11 first cause kept", v, 8'h01);
      chk("R12 mcd_en kept", mcd_en, 1);
      chk("R12 sup_mon_en kept", sup_mon_en, 1);

      por_n = 0; idle(2);
      chk("R3 por clears mcd_en", mcd_en, 0);
      por_n = 1; drain(n);
      rd(v); chk("R1 read after second por", v, 8'h02);
      idle(2);
      finish_run();
   end
endmodule